// File: doc/BRIEF.md
# Per-Instruction Register Access Wait-State Generator

This block sits between a bus master and a bank of sound-chip registers. It decides how many bus wait cycles each register access costs. Charges follow the instruction, not the single access. The first accepted access of an instruction costs one unit of four clock cycles. Later accesses from the same instruction are free. The exception is a multi-register block move, which pays one more unit each time its running access count reaches a multiple of four.

Each access presents a tag that identifies the instruction issuing it. A tag that differs from the one of the previous accepted access marks a new instruction. So does any tag on the first accepted access after reset. An access flagged as a rejected shadow-address write is dropped completely. It costs nothing and leaves the instruction tracking unchanged. Charged units go into a single countdown of owed cycles. A unit that arises while a wait is still running is served straight after the current one, with no gap between them. The block drives a wait request and its complement, a ready signal, back to the master.

Top module: `instr_wait_gen`

## Requirements
- R1: After reset, wait_req is low and ready is high.
- R2: An accepted access (acc_valid high, shadow_rej low) opens a new instruction in two cases. The first is when its instr_tag differs from the tag of the previous accepted access. The second is when it is the first accepted access since reset. Opening a new instruction charges one unit, and wait_req rises in the next cycle.
- R3: Accepted accesses with the same tag as the open instruction and block_move low charge nothing. For example, four such accesses in a row cost 4 wait cycles in total.
- R4: Within one instruction, accesses are numbered from 1, and the access that opens the instruction is number 1. An access with block_move high whose number is a multiple of BLOCK_EVERY (4) charges one extra unit. A 3-access block move therefore costs 4 cycles, a 7-access one costs 8 (units on accesses 1 and 4), and a 15-access one costs 16.
- R5: An access with shadow_rej high charges nothing. It does not change the remembered tag or the access number.
- R6: Each charged unit keeps wait_req high for exactly UNIT_CYC (4) cycles. Units charged during a running wait are queued and served back-to-back. wait_req stays high for 4 cycles per unit in total, with no gap.
- R7: ready is low in every cycle in which wait_req is high, and high in the cycle after the last wait cycle.
- R8: Up to MAX_UNITS (8) units may be owed at once without loss. For example, 8 new instructions on consecutive cycles cost 32 wait cycles.
- R9: When acc_valid is low, the other inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A register access is presented this cycle |
| instr_tag | input | TAG_W | Identifier of the instruction issuing the access |
| block_move | input | 1 | The issuing instruction is a multi-register block move |
| shadow_rej | input | 1 | The access is a rejected shadow-address write and must be ignored |
| wait_req | output | 1 | Wait request to the bus master |
| ready | output | 1 | Ready back to the bus master, the inverse of wait_req |

## Verification
The assertions assume that the owed-cycle count never needs more than MAX_UNITS units. To keep to that, the stimulus issues at most eight charging accesses before the wait drains. It also assumes that instruction tags only repeat on purpose. The stimulus changes tag between sequences, except where a test deliberately reuses a tag to probe shadow rejection, idle cycles and the clearing of the tag on reset. Accesses may arrive while a wait is running, because queued charging is part of the behaviour under test.

// File: rtl/iwg_pkg.sv
package iwg_pkg;

  // Access count after one more block-move access, wrapping at 'every'.
  function automatic int unsigned next_count(input int unsigned cnt,
                                             input int unsigned every);
    return (cnt + 1 >= every) ? 0 : cnt + 1;
  endfunction

  // Owed cycles after one clock: one drained, plus a unit if charged.
  function automatic int unsigned refill(input int unsigned rem,
                                         input bit          chg,
                                         input int unsigned unit);
    int unsigned r;
    r = (rem != 0) ? rem - 1 : 0;
    return chg ? r + unit : r;
  endfunction

endpackage

// File: rtl/iwg_tracker.sv
module iwg_tracker #(
  parameter int TAG_W       = 8,
  parameter int BLOCK_EVERY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [TAG_W-1:0] instr_tag,
  input  logic             block_move,
  input  logic             shadow_rej,
  output logic             new_instr,
  output logic             block_tick,
  output logic             charge
);
  localparam int CNT_W = (BLOCK_EVERY > 2) ? $clog2(BLOCK_EVERY) : 1;

  logic [TAG_W-1:0] tag_q;
  logic             seen_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_step;
  logic             accepted;

  assign accepted   = acc_valid & ~shadow_rej;
  assign new_instr  = accepted & (~seen_q | (tag_q != instr_tag));
  assign cnt_step   = CNT_W'(iwg_pkg::next_count(int'(cnt_q), BLOCK_EVERY));
  assign block_tick = accepted & ~new_instr & block_move & (cnt_step == '0);
  assign charge     = new_instr | block_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (new_instr) begin
      tag_q  <= instr_tag;
      seen_q <= 1'b1;
      cnt_q  <= CNT_W'(1 % BLOCK_EVERY);
    end else if (accepted && block_move) begin
      cnt_q  <= cnt_step;
    end
  end

  assert_tag_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    new_instr |=> (seen_q && tag_q == $past(instr_tag)));

  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && shadow_rej) |=> ($stable(tag_q) && $stable(cnt_q) && $stable(seen_q)));

  assert_block_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !shadow_rej && !block_move && !new_instr) |=> $stable(cnt_q));

endmodule

// File: rtl/iwg_timer.sv
module iwg_timer #(
  parameter int UNIT_CYC  = 4,
  parameter int MAX_UNITS = 8,
  parameter int REM_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             charge,
  output logic             wait_req,
  output logic [REM_W-1:0] wait_left
);
  localparam int MAX_REM = MAX_UNITS * UNIT_CYC;

  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] rem_d;

  assign rem_d     = REM_W'(iwg_pkg::refill(int'(rem_q), charge, UNIT_CYC));
  assign wait_req  = (rem_q != '0);
  assign wait_left = rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    charge |-> (int'(rem_q) + UNIT_CYC - ((rem_q != '0) ? 1 : 0) <= MAX_REM));

endmodule

// File: rtl/instr_wait_gen.sv
module instr_wait_gen #(
  parameter int TAG_W       = 8,
  parameter int UNIT_CYC    = 4,
  parameter int BLOCK_EVERY = 4,
  parameter int MAX_UNITS   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [TAG_W-1:0] instr_tag,
  input  logic             block_move,
  input  logic             shadow_rej,
  output logic             wait_req,
  output logic             ready
);
  localparam int REM_W = $clog2(MAX_UNITS * UNIT_CYC + 1);

  logic             new_instr;
  logic             block_tick;
  logic             charge;
  logic [REM_W-1:0] wait_left;

  iwg_tracker #(.TAG_W(TAG_W), .BLOCK_EVERY(BLOCK_EVERY)) tracker_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .instr_tag(instr_tag),
    .block_move(block_move), .shadow_rej(shadow_rej),
    .new_instr(new_instr), .block_tick(block_tick), .charge(charge)
  );

  iwg_timer #(.UNIT_CYC(UNIT_CYC), .MAX_UNITS(MAX_UNITS), .REM_W(REM_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .charge(charge),
    .wait_req(wait_req), .wait_left(wait_left)
  );

  assign ready = ~wait_req;

  assert_shadow_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && shadow_rej) |=>
      (wait_left == (($past(wait_left) == '0) ? '0 : $past(wait_left) - 1'b1)));

  assert_queue_unit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    charge |=> (int'(wait_left) == int'($past(wait_left))
                 - (($past(wait_left) != '0) ? 1 : 0) + UNIT_CYC));

  assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!charge && wait_left != '0) |=> (wait_left == $past(wait_left) - 1'b1));

  assert_ready_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_req) |-> (ready && $past(wait_left) == 1));

  assert_idle_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !charge);

endmodule

// File: tb/instr_wait_gen_tb.sv
module instr_wait_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [7:0] instr_tag = '0;
  logic       block_move = 1'b0;
  logic       shadow_rej = 1'b0;
  logic       wait_req;
  logic       ready;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int wcnt = 0;
  bit done = 0;

  // reference model state
  int  owe = 0;
  bit  m_seen = 0;
  int  m_tag = 0;
  int  m_num = 0;

  instr_wait_gen dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .instr_tag(instr_tag),
    .block_move(block_move), .shadow_rej(shadow_rej),
    .wait_req(wait_req), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: instruction access numbering and owed-cycle budget
  always @(posedge clk) begin
    int units;
    units = 0;
    if (!rst_n) begin
      owe = 0; m_seen = 0; m_tag = 0; m_num = 0;
    end else begin
      if (acc_valid && !shadow_rej) begin
        if (!m_seen || m_tag != int'(instr_tag)) begin
          m_seen = 1; m_tag = int'(instr_tag); m_num = 1; units = 1;
        end else if (block_move) begin
          m_num++;
          if (m_num % 4 == 0) units = 1;
        end
      end
      if (owe > 0) owe--;
      owe += 4 * units;
    end
    if (wait_req) wcnt++;
    cyc++;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(wait_req == (owe > 0), "R6 wait_req", int'(wait_req), int'(owe > 0));
      check(ready == (owe == 0), "R7 ready", int'(ready), int'(owe == 0));
    end
  end

  task automatic drain();
    while (wait_req) @(negedge clk);
  endtask

  task automatic run_seq(input int tag, input int n, input bit bm, input bit sh,
                         input int exp, input string req);
    int base;
    drain();
    base = wcnt;
    for (int i = 0; i < n; i++) begin
      acc_valid = 1'b1; instr_tag = 8'(tag); block_move = bm; shadow_rej = sh;
      @(negedge clk);
    end
    acc_valid = 1'b0; block_move = 1'b0; shadow_rej = 1'b0;
    @(negedge clk);
    drain();
    check(wcnt - base == exp, req, wcnt - base, exp);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check(!wait_req && ready, "R1 reset state", int'(wait_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wait_req && ready, "R1 after release", int'(ready), 1);

    run_seq(1, 1, 0, 0, 4, "R2 single access");
    run_seq(2, 4, 0, 0, 4, "R3 same instruction");
    run_seq(3, 3, 1, 0, 4, "R4 block move 3");
    run_seq(4, 7, 1, 0, 8, "R4 block move 7");
    run_seq(5, 15, 1, 0, 16, "R4 block move 15");
    run_seq(6, 2, 0, 1, 0, "R5 shadow ignored");
    run_seq(5, 1, 0, 0, 0, "R5 tag kept over shadow");
    run_seq(7, 2, 1, 1, 0, "R5 shadow block move");

    // R9: idle cycles with changing inputs change nothing
    drain();
    base = wcnt;
    for (int i = 0; i < 4; i++) begin
      acc_valid = 1'b0; instr_tag = 8'(40 + i); block_move = 1'b1;
      @(negedge clk);
    end
    block_move = 1'b0;
    check(wcnt == base && !wait_req, "R9 idle inputs", wcnt - base, 0);
    run_seq(5, 1, 0, 0, 0, "R9 tag unchanged by idle");

    // R8 / R6: eight new instructions back-to-back queue 32 cycles
    drain();
    base = wcnt;
    for (int i = 0; i < 8; i++) begin
      acc_valid = 1'b1; instr_tag = 8'(100 + i);
      @(negedge clk);
    end
    acc_valid = 1'b0;
    @(negedge clk);
    drain();
    check(wcnt - base == 32, "R8 queued units", wcnt - base, 32);

    // R2: reset forgets the tag, so the same tag opens a new instruction
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!wait_req && ready, "R1 mid reset", int'(wait_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_seq(107, 1, 0, 0, 4, "R2 first after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule